// File: doc/BRIEF.md
# Integer Execute Unit with Selectable Carry Behaviour

This block is the integer execute stage of a small processor pipeline. A decoded operation code picks one function: addition, reverse subtraction (B minus A), signed or unsigned compare, one of four bitwise operations, a one-bit right shift, or sign extension of a byte or a halfword. Operand A always comes from a register. Operand B comes from a register or from an immediate that is already extended to full width, and `use_imm` chooses between them. The result and the carry it would produce are combinational.

A single carry flag is held in a register. Some add and subtract forms use the stored flag as their carry-in. Some forms write the carry out of the sum into the flag, and the "keep" forms leave the flag as it is. The flag changes only on a rising clock edge, and only when `op_valid` marks the operation as real. The `carry_next` output always shows the value the flag would take on that edge if the operation were issued.

Top module: `alu_core`

## Requirements
- R1: While `rst_n` is low the carry flag is cleared, and `carry_flag` reads 0 after reset.
- R2: Code 0 (add) gives A+B. Code 1 (reverse subtract) gives B+~A+1. Both report the carry out of the sum on `carry_next`.
- R3: Code 2 gives A+B+flag. Code 3 gives B+~A+flag. Both report the carry out of the sum on `carry_next`.
- R4: On a rising edge with `op_valid` high, `carry_flag` takes the value `carry_next` showed before that edge.
- R5: Codes 4, 5, 6 and 7 give the same results as codes 0, 1, 2 and 3. For these codes `carry_next` equals the current flag, so the flag does not change.
- R6: Code 8 (signed compare) gives B+~A+1. When bit 31 of A differs from bit 31 of B, result bit 31 is replaced by bit 31 of B.
- R7: Code 9 (unsigned compare) gives the same sum. When bit 31 of A differs from bit 31 of B, result bit 31 is replaced by bit 31 of A.
- R8: Code 10 gives A|B, code 11 gives A&B, code 12 gives A^B and code 13 gives A&~B.
- R9: When `use_imm` is 1, `opb_imm` is used as B. When `use_imm` is 0, `opb_reg` is used as B.
- R10: Codes 14, 15 and 16 shift A right by one bit and report A bit 0 on `carry_next`. Bit 31 of the result is the old A bit 31 for code 14, the current flag for code 15, and 0 for code 16.
- R11: Code 17 copies bit 7 of A into bits 31:8. Code 18 copies bit 15 of A into bits 31:16.
- R12: The flag stays unchanged when `op_valid` is low. It also stays unchanged for codes 8 to 13, 17 and 18. Codes 19 to 31 give a result of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the carry flag |
| op_valid | input | 1 | Issue strobe; the flag updates only when this is high |
| op_code | input | 5 | Decoded operation select |
| opa | input | 32 | Operand A |
| opb_reg | input | 32 | Register source for operand B |
| opb_imm | input | 32 | Extended immediate source for operand B |
| use_imm | input | 1 | Selects the immediate as operand B |
| result | output | 32 | Combinational result |
| carry_next | output | 1 | Flag value after this operation |
| carry_flag | output | 1 | Stored carry flag |

## Verification
The add and subtract forms are driven with operands whose sums wrap past the top bit and with operands whose sums do not. The same forms are run with the flag set and with the flag clear, which separates the carry-using and carry-keeping forms from the plain ones. The compare cases use operands with equal signs and operands with opposite signs, so the bit-31 patch is shown to pick B for the signed form and A for the unsigned form. The shift and sign-extension cases use inputs where bit 0, the sign bit and the flag take different values, so a wrong fill source shows up in the result.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int OP_W = 5;

    typedef enum logic [OP_W-1:0] {
        OP_ADD    = 5'd0,
        OP_RSUB   = 5'd1,
        OP_ADDC   = 5'd2,
        OP_RSUBC  = 5'd3,
        OP_ADDK   = 5'd4,
        OP_RSUBK  = 5'd5,
        OP_ADDKC  = 5'd6,
        OP_RSUBKC = 5'd7,
        OP_CMPS   = 5'd8,
        OP_CMPU   = 5'd9,
        OP_OR     = 5'd10,
        OP_AND    = 5'd11,
        OP_XOR    = 5'd12,
        OP_ANDN   = 5'd13,
        OP_SRA    = 5'd14,
        OP_SRC    = 5'd15,
        OP_SRL    = 5'd16,
        OP_SEXT8  = 5'd17,
        OP_SEXT16 = 5'd18
    } alu_op_e;

    typedef struct packed {
        logic carry;
    } alu_state_t;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             reverse,
    input  logic             use_flag,
    input  logic             flag,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);
    logic [WIDTH-1:0] a_term;
    logic             cin;
    logic [WIDTH:0]   wide;

    always_comb begin
        a_term = reverse ? ~a : a;
        cin    = use_flag ? flag : reverse;
        wide   = {1'b0, b} + {1'b0, a_term} + {{WIDTH{1'b0}}, cin};
        sum    = wide[WIDTH-1:0];
        cout   = wide[WIDTH];
    end
endmodule

// File: rtl/alu_bitops.sv
module alu_bitops #(
    parameter int WIDTH = 32
) (
    input  alu_pkg::alu_op_e op,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             flag,
    output logic [WIDTH-1:0] res,
    output logic             shift_out
);
    import alu_pkg::*;

    localparam int BYTE_W = 8;
    localparam int HALF_W = 16;

    logic [WIDTH-2:0] shifted;

    always_comb begin
        shifted   = a[WIDTH-1:1];
        shift_out = a[0];
        res       = '0;
        case (op)
            OP_OR:     res = a | b;
            OP_AND:    res = a & b;
            OP_XOR:    res = a ^ b;
            OP_ANDN:   res = a & ~b;
            OP_SRA:    res = {a[WIDTH-1], shifted};
            OP_SRC:    res = {flag, shifted};
            OP_SRL:    res = {1'b0, shifted};
            OP_SEXT8:  res = {{(WIDTH-BYTE_W){a[BYTE_W-1]}}, a[BYTE_W-1:0]};
            OP_SEXT16: res = {{(WIDTH-HALF_W){a[HALF_W-1]}}, a[HALF_W-1:0]};
            default:   res = '0;
        endcase
    end
endmodule

// File: rtl/alu_core.sv
module alu_core #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [4:0]       op_code,
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb_reg,
    input  logic [WIDTH-1:0] opb_imm,
    input  logic             use_imm,
    output logic [WIDTH-1:0] result,
    output logic             carry_next,
    output logic             carry_flag
);
    import alu_pkg::*;

    localparam int MSB = WIDTH - 1;

    alu_op_e          op;
    alu_state_t       st_q, st_d;
    logic [WIDTH-1:0] opb;
    logic             arith_rev, arith_use_flag;
    logic [WIDTH-1:0] sum;
    logic             sum_co;
    logic [WIDTH-1:0] bit_res;
    logic             bit_co;

    assign op  = alu_op_e'(op_code);
    assign opb = use_imm ? opb_imm : opb_reg;

    // Arithmetic codes 0..7: bit0 reverse, bit1 flag carry-in, bit2 keep.
    always_comb begin
        if (op_code[4:3] == 2'b00) begin
            arith_rev      = op_code[0];
            arith_use_flag = op_code[1];
        end else begin
            arith_rev      = 1'b1;
            arith_use_flag = 1'b0;
        end
    end

    alu_addsub #(.WIDTH(WIDTH)) addsub_i (
        .a        (opa),
        .b        (opb),
        .reverse  (arith_rev),
        .use_flag (arith_use_flag),
        .flag     (st_q.carry),
        .sum      (sum),
        .cout     (sum_co)
    );

    alu_bitops #(.WIDTH(WIDTH)) bitops_i (
        .op        (op),
        .a         (opa),
        .b         (opb),
        .flag      (st_q.carry),
        .res       (bit_res),
        .shift_out (bit_co)
    );

    always_comb begin
        st_d       = st_q;
        result     = '0;
        carry_next = st_q.carry;
        case (op)
            OP_ADD, OP_RSUB, OP_ADDC, OP_RSUBC: begin
                result     = sum;
                carry_next = sum_co;
            end
            OP_ADDK, OP_RSUBK, OP_ADDKC, OP_RSUBKC: begin
                result = sum;
            end
            OP_CMPS, OP_CMPU: begin
                result = sum;
                if (opa[MSB] ^ opb[MSB])
                    result[MSB] = (op == OP_CMPS) ? opb[MSB] : opa[MSB];
            end
            OP_OR, OP_AND, OP_XOR, OP_ANDN, OP_SEXT8, OP_SEXT16: begin
                result = bit_res;
            end
            OP_SRA, OP_SRC, OP_SRL: begin
                result     = bit_res;
                carry_next = bit_co;
            end
            default: result = '0;
        endcase
        if (op_valid)
            st_d.carry = carry_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign carry_flag = st_q.carry;

endmodule

// File: rtl/alu_core_chk.sv
module alu_core_chk #(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             op_valid,
    input logic [4:0]       op_code,
    input logic [WIDTH-1:0] opa,
    input logic [WIDTH-1:0] opb_reg,
    input logic [WIDTH-1:0] opb_imm,
    input logic             use_imm,
    input logic [WIDTH-1:0] result,
    input logic             carry_next,
    input logic             carry_flag
);
    logic [WIDTH-1:0] b_eff;
    assign b_eff = use_imm ? opb_imm : opb_reg;

    // R1
    flag_reset_chk: assert property (@(posedge clk) !rst_n |=> !carry_flag);

    // R4
    flag_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> carry_flag == $past(carry_next));

    // R12
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> $stable(carry_flag));

    // R5
    keep_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code >= 5'd4 && op_code <= 5'd7) |-> carry_next == carry_flag);

    // R7
    cmpu_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 5'd9 && (opa[WIDTH-1] != b_eff[WIDTH-1]))
            |-> result[WIDTH-1] == opa[WIDTH-1]);

    // R10
    srl_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_code == 5'd16 |-> (!result[WIDTH-1] && carry_next == opa[0]));

    // R11
    sext8_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_code == 5'd17 |-> result == {{(WIDTH-8){opa[7]}}, opa[7:0]});
endmodule

bind alu_core alu_core_chk #(.WIDTH(WIDTH)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_valid   (op_valid),
    .op_code    (op_code),
    .opa        (opa),
    .opb_reg    (opb_reg),
    .opb_imm    (opb_imm),
    .use_imm    (use_imm),
    .result     (result),
    .carry_next (carry_next),
    .carry_flag (carry_flag)
);

// File: tb/alu_core_tb.sv
module alu_core_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [4:0]  op_code = '0;
    logic [31:0] opa = '0;
    logic [31:0] opb_reg = '0;
    logic [31:0] opb_imm = '0;
    logic        use_imm = 1'b0;
    logic [31:0] result;
    logic        carry_next;
    logic        carry_flag;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    alu_core dut_i (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .opa(opa), .opb_reg(opb_reg), .opb_imm(opb_imm), .use_imm(use_imm),
        .result(result), .carry_next(carry_next), .carry_flag(carry_flag)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive at negedge, check combinational outputs, then check the flag after the edge.
    task automatic do_op(input string tag, input logic vld, input logic [4:0] code,
                         input logic [31:0] a, input logic [31:0] b,
                         input logic imm_sel, input logic [31:0] imm,
                         input logic [31:0] exp_res, input logic exp_cn, input logic exp_flag);
        @(negedge clk);
        op_valid = vld; op_code = code; opa = a; opb_reg = b;
        use_imm = imm_sel; opb_imm = imm;
        #1;
        check({tag, " result"}, result, exp_res);
        check({tag, " carry_next"}, {31'd0, carry_next}, {31'd0, exp_cn});
        @(posedge clk);
        #1;
        check({tag, " flag"}, {31'd0, carry_flag}, {31'd0, exp_flag});
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset flag", {31'd0, carry_flag}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_add_rsub;
        do_op("R2 add wrap",   1, 5'd0, 32'hFFFF_FFFF, 32'd1, 0, 0, 32'h0, 1, 1);
        do_op("R2 rsub neg",   1, 5'd1, 32'd5, 32'd3, 0, 0, 32'hFFFF_FFFE, 0, 0);
        do_op("R2 rsub pos",   1, 5'd1, 32'd3, 32'd5, 0, 0, 32'd2, 1, 1);
        do_op("R4 add nowrap", 1, 5'd0, 32'd7, 32'd8, 0, 0, 32'd15, 0, 0);
        do_op("R4 add set",    1, 5'd0, 32'h8000_0000, 32'h8000_0000, 0, 0, 32'h0, 1, 1);
    endtask

    task automatic t_carry_in;
        do_op("R3 addc f1",  1, 5'd2, 32'd1, 32'd2, 0, 0, 32'd4, 0, 0);
        do_op("R3 rsubc f0", 1, 5'd3, 32'd3, 32'd5, 0, 0, 32'd1, 1, 1);
        do_op("R3 addc wrap",1, 5'd2, 32'hFFFF_FFFF, 32'd0, 0, 0, 32'h0, 1, 1);
    endtask

    task automatic t_keep;
        do_op("R5 addk f1",   1, 5'd4, 32'hFFFF_FFFF, 32'd1, 0, 0, 32'h0, 1, 1);
        do_op("R5 rsubk f1",  1, 5'd5, 32'd5, 32'd3, 0, 0, 32'hFFFF_FFFE, 1, 1);
        do_op("R5 clear",     1, 5'd0, 32'd1, 32'd1, 0, 0, 32'd2, 0, 0);
        do_op("R5 addk f0",   1, 5'd4, 32'hFFFF_FFFF, 32'd1, 0, 0, 32'h0, 0, 0);
        do_op("R5 addkc f0",  1, 5'd6, 32'd1, 32'd2, 0, 0, 32'd3, 0, 0);
        do_op("R5 rsubkc f0", 1, 5'd7, 32'd3, 32'd5, 0, 0, 32'd1, 0, 0);
    endtask

    task automatic t_compare;
        do_op("R6 set flag",   1, 5'd0, 32'hFFFF_FFFF, 32'd1, 0, 0, 32'h0, 1, 1);
        do_op("R6 cmps diff",  1, 5'd8, 32'd1, 32'h8000_0000, 0, 0, 32'hFFFF_FFFF, 1, 1);
        do_op("R7 cmpu diff",  1, 5'd9, 32'd1, 32'h8000_0000, 0, 0, 32'h7FFF_FFFF, 1, 1);
        do_op("R6 cmps same",  1, 5'd8, 32'd3, 32'd10, 0, 0, 32'd7, 1, 1);
        do_op("R7 cmpu same",  1, 5'd9, 32'd10, 32'd3, 0, 0, 32'hFFFF_FFF9, 1, 1);
        do_op("R7 cmpu imm",   1, 5'd9, 32'h8000_0000, 32'd0, 1, 32'd5, 32'h8000_0005, 1, 1);
    endtask

    task automatic t_logic;
        do_op("R8 or",        1, 5'd10, 32'hF0F0_00FF, 32'h0FF0_0F0F, 0, 32'hDEAD_BEEF, 32'hFFF0_0FFF, 1, 1);
        do_op("R8 and",       1, 5'd11, 32'hF0F0_00FF, 32'h0FF0_0F0F, 0, 32'hDEAD_BEEF, 32'h00F0_000F, 1, 1);
        do_op("R8 xor",       1, 5'd12, 32'hF0F0_00FF, 32'h0FF0_0F0F, 0, 32'hDEAD_BEEF, 32'hFF00_0FF0, 1, 1);
        do_op("R8 andn",      1, 5'd13, 32'hF0F0_00FF, 32'h0FF0_0F0F, 0, 32'hDEAD_BEEF, 32'hF000_00F0, 1, 1);
        do_op("R9 and imm",   1, 5'd11, 32'hF0F0_00FF, 32'h1234_5678, 1, 32'h0FF0_0F0F, 32'h00F0_000F, 1, 1);
        do_op("R9 andn imm",  1, 5'd13, 32'hF0F0_00FF, 32'hFFFF_FFFF, 1, 32'h0FF0_0F0F, 32'hF000_00F0, 1, 1);
    endtask

    task automatic t_shift;
        do_op("R10 sra",     1, 5'd14, 32'h8000_0003, 32'd0, 0, 0, 32'hC000_0001, 1, 1);
        do_op("R10 srl",     1, 5'd16, 32'h8000_0002, 32'd0, 0, 0, 32'h4000_0001, 0, 0);
        do_op("R10 src f0",  1, 5'd15, 32'h0000_0003, 32'd0, 0, 0, 32'h0000_0001, 1, 1);
        do_op("R10 src f1",  1, 5'd15, 32'h0000_0002, 32'd0, 0, 0, 32'h8000_0001, 0, 0);
    endtask

    task automatic t_sext;
        do_op("R11 set flag",  1, 5'd0, 32'hFFFF_FFFF, 32'd1, 0, 0, 32'h0, 1, 1);
        do_op("R11 sext8 neg", 1, 5'd17, 32'h1234_5680, 32'd0, 0, 0, 32'hFFFF_FF80, 1, 1);
        do_op("R11 sext8 pos", 1, 5'd17, 32'hFFFF_7F7F, 32'd0, 0, 0, 32'h0000_007F, 1, 1);
        do_op("R11 sext16 ng", 1, 5'd18, 32'h0000_8001, 32'd0, 0, 0, 32'hFFFF_8001, 1, 1);
        do_op("R11 sext16 ps", 1, 5'd18, 32'hFFFF_1234, 32'd0, 0, 0, 32'h0000_1234, 1, 1);
    endtask

    task automatic t_idle;
        do_op("R12 invalid add", 0, 5'd0, 32'd1, 32'd1, 0, 0, 32'd2, 0, 1);
        do_op("R12 invalid srl", 0, 5'd16, 32'd2, 32'd0, 0, 0, 32'd1, 0, 1);
        do_op("R12 unused code", 1, 5'd25, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, 32'h0, 1, 1);
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    initial begin
        t_reset();
        t_add_rsub();
        t_carry_in();
        t_keep();
        t_compare();
        t_logic();
        t_shift();
        t_sext();
        t_idle();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule